// File: doc/BRIEF.md
# Paravirtual Queue Device Register Interface

This block is the register file on the device side of a memory-mapped paravirtual device that exposes a small set of descriptor queues. A guest driver talks to it over a plain 32-bit word bus that has an address, a write strobe, write data, a read strobe and read data. The block holds a global page size and a queue-select register. The size, alignment and page frame of each queue are reached through the select register. The block drives the current configuration of every queue toward the queue engine. A write to the notify register becomes a one-cycle pulse that carries the written queue index. Two event inputs stand in for the queue engine: one for used buffers and one for configuration changes. They set cause bits in an interrupt status register. A single interrupt line stays high until the guest clears every cause by writing an acknowledge mask.

All registers are one 32-bit word and are read and written whole. A read returns its data on the cycle after the read strobe is sampled. Each register is readable, writable, or both. An access in the direction a register does not support is harmless: a write has no effect and a read returns zero.

Top module: `pvq_mmio_regs`

## Requirements
- R1: After reset, every per-queue size, alignment and page frame is 0, the page size is 0, the interrupt status is 0, `irq_o` is low and `notify_o` is low.
- R2: A write to QSEL (offset 0x04) chooses the queue. Later writes to QSIZE (0x08), QALIGN (0x0C) and QPFN (0x10) reach only that queue. A read of QPFN returns the page frame of the selected queue.
- R3: A read of QPFN for a queue whose page frame was never written returns 0.
- R4: A read of MAXSZ (0x00) returns MAX_ENTRIES when the selected index is below NUM_Q and 0 otherwise. With an index at NUM_Q or above, writes to QSIZE, QALIGN and QPFN change no queue, and a read of QPFN returns 0.
- R5: A read of QBASE (0x24) returns the low 32 bits of the selected queue's page frame multiplied by the page size last written to PGSIZE (0x14).
- R6: `irq_o` is high exactly when at least one bit of the interrupt status is set.
- R7: A write to IRQACK (0x20) clears each status bit whose mask bit is 1 and leaves the bits whose mask bit is 0 unchanged.
- R8: A pulse on `evt_used_i` sets status bit 0, and a pulse on `evt_cfg_i` sets status bit 1. IRQSTAT (0x1C) reads the status in bits 1:0.
- R9: When an event and an acknowledge of the same status bit arrive in the same cycle, the bit ends up set.
- R10: Writes to the read-only registers MAXSZ, IRQSTAT and QBASE are ignored. Reads of the write-only registers QSEL, QSIZE, QALIGN, PGSIZE, NOTIFY (0x18) and IRQACK return 0. Unmapped offsets read 0 and ignore writes.
- R11: A write to NOTIFY makes `notify_o` high for exactly the next cycle, with `notify_qidx_o` equal to the written value.
- R12: `q_size_o`, `q_align_o` and `q_pfn_o` carry each queue's configuration in slice [q*32 +: 32], and `page_size_o` carries the page size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 8 | Byte offset of the accessed register |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| evt_used_i | input | 1 | Used-buffer event from the queue engine |
| evt_cfg_i | input | 1 | Configuration-change event |
| irq_o | output | 1 | Level interrupt |
| notify_o | output | 1 | One-cycle queue notify pulse |
| notify_qidx_o | output | 32 | Queue index that goes with the notify pulse |
| page_size_o | output | 32 | Guest page size |
| q_size_o | output | NUM_Q*32 | Configured size of each queue |
| q_align_o | output | NUM_Q*32 | Used-ring alignment of each queue |
| q_pfn_o | output | NUM_Q*32 | Page frame of each queue |

## Verification
The bench selects an index beyond the last queue and writes a page frame there. A design that decoded only the low index bits would alias that write onto a real queue and corrupt it. It also raises a used-buffer event in the same cycle as an acknowledge of that bit; a design that gave priority to the clear would lose the interrupt. Read-only registers are written with nonzero data and write-only registers are read back. A decoder that treated every offset as both readable and writable would leak stale values or overwrite status. The bench also rescales the page size after the page frames are set, which catches a design that latched the base address at the time of the write.

// File: rtl/pvq_pkg.sv
package pvq_pkg;

    localparam int REG_W = 32;
    localparam int OFS_W = 8;

    typedef logic [OFS_W-1:0] ofs_t;

    // register byte offsets
    localparam ofs_t OFS_MAXSZ  = 8'h00; // R
    localparam ofs_t OFS_QSEL   = 8'h04; // W
    localparam ofs_t OFS_QSIZE  = 8'h08; // W
    localparam ofs_t OFS_QALIGN = 8'h0C; // W
    localparam ofs_t OFS_QPFN   = 8'h10; // RW
    localparam ofs_t OFS_PGSIZE = 8'h14; // W
    localparam ofs_t OFS_NOTIFY = 8'h18; // W
    localparam ofs_t OFS_IRQSTAT= 8'h1C; // R
    localparam ofs_t OFS_IRQACK = 8'h20; // W
    localparam ofs_t OFS_QBASE  = 8'h24; // R

    // interrupt cause bits
    localparam int ST_W    = 2;
    localparam int ST_USED = 0;
    localparam int ST_CFG  = 1;

endpackage

// File: rtl/pvq_queue_bank.sv
module pvq_queue_bank #(
    parameter int NUM_Q = 4,
    parameter int DW    = 32,
    localparam int IDXW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_size_i,
    input  logic                wr_align_i,
    input  logic                wr_pfn_i,
    input  logic [IDXW-1:0]     idx_i,
    input  logic [DW-1:0]       wdata_i,
    output logic [NUM_Q*DW-1:0] size_o,
    output logic [NUM_Q*DW-1:0] align_o,
    output logic [NUM_Q*DW-1:0] pfn_o
);

    typedef struct packed {
        logic [NUM_Q-1:0][DW-1:0] size;
        logic [NUM_Q-1:0][DW-1:0] align;
        logic [NUM_Q-1:0][DW-1:0] pfn;
    } bank_t;

    bank_t st_d, st_q;
    logic  idx_ok;

    assign idx_ok = (int'(idx_i) < NUM_Q);

    always_comb begin
        st_d = st_q;
        if (idx_ok) begin
            if (wr_size_i)  st_d.size[idx_i]  = wdata_i;
            if (wr_align_i) st_d.align[idx_i] = wdata_i;
            if (wr_pfn_i)   st_d.pfn[idx_i]   = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_flat
        assign size_o[g*DW +: DW]  = st_q.size[g];
        assign align_o[g*DW +: DW] = st_q.align[g];
        assign pfn_o[g*DW +: DW]   = st_q.pfn[g];
    end

    // a page frame write lands in the addressed queue only
    assert_pfn_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pfn_i && idx_ok) |=> (st_q.pfn[$past(idx_i)] == $past(wdata_i)));

endmodule

// File: rtl/pvq_irq_status.sv
module pvq_irq_status #(
    parameter int ST_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_i,
    input  logic            ack_en_i,
    input  logic [ST_W-1:0] ack_mask_i,
    output logic [ST_W-1:0] status_o,
    output logic            irq_o
);

    typedef struct packed {
        logic [ST_W-1:0] status;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_en_i) st_d.status = st_d.status & ~ack_mask_i;
        // a new cause is applied after the clear so it is never lost
        st_d.status = st_d.status | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = |st_q.status;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en_i |=> ((status_o & $past(ack_mask_i & ~set_i)) == '0));

    assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_en_i && set_i == '0) |=> $stable(status_o));

endmodule

// File: rtl/pvq_mmio_regs.sv
module pvq_mmio_regs
    import pvq_pkg::*;
#(
    parameter int NUM_Q       = 4,
    parameter int MAX_ENTRIES = 256,
    localparam int DW   = REG_W,
    localparam int IDXW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OFS_W-1:0]    bus_addr_i,
    input  logic                bus_wr_i,
    input  logic [DW-1:0]       bus_wdata_i,
    input  logic                bus_rd_i,
    output logic [DW-1:0]       bus_rdata_o,
    input  logic                evt_used_i,
    input  logic                evt_cfg_i,
    output logic                irq_o,
    output logic                notify_o,
    output logic [DW-1:0]       notify_qidx_o,
    output logic [DW-1:0]       page_size_o,
    output logic [NUM_Q*DW-1:0] q_size_o,
    output logic [NUM_Q*DW-1:0] q_align_o,
    output logic [NUM_Q*DW-1:0] q_pfn_o
);

    typedef struct packed {
        logic [DW-1:0] sel;
        logic [DW-1:0] page;
        logic [DW-1:0] rdata;
        logic          notify;
        logic [DW-1:0] nidx;
    } top_t;

    top_t st_d, st_q;

    logic            sel_ok;
    logic [IDXW-1:0] sel_idx;
    logic            wr_size, wr_align, wr_pfn, ack_en;
    logic [ST_W-1:0] status, set_vec;
    logic [DW-1:0]   pfn_arr [NUM_Q];
    logic [DW-1:0]   pfn_sel;
    logic [DW-1:0]   base_sel;
    logic            rd_wo;

    assign sel_ok  = (st_q.sel < DW'(NUM_Q));
    assign sel_idx = st_q.sel[IDXW-1:0];
    assign set_vec = {evt_cfg_i, evt_used_i};

    for (genvar g = 0; g < NUM_Q; g++) begin : g_pfn
        assign pfn_arr[g] = q_pfn_o[g*DW +: DW];
    end

    assign pfn_sel  = sel_ok ? pfn_arr[sel_idx] : '0;
    assign base_sel = pfn_sel * st_q.page;

    // write strobes toward the sub-blocks, gated by a valid selection
    always_comb begin
        wr_size  = bus_wr_i && (bus_addr_i == OFS_QSIZE)  && sel_ok;
        wr_align = bus_wr_i && (bus_addr_i == OFS_QALIGN) && sel_ok;
        wr_pfn   = bus_wr_i && (bus_addr_i == OFS_QPFN)   && sel_ok;
        ack_en   = bus_wr_i && (bus_addr_i == OFS_IRQACK);
    end

    always_comb begin
        st_d        = st_q;
        st_d.notify = 1'b0;
        st_d.nidx   = '0;
        st_d.rdata  = '0;
        if (bus_wr_i) begin
            unique case (bus_addr_i)
                OFS_QSEL:   st_d.sel  = bus_wdata_i;
                OFS_PGSIZE: st_d.page = bus_wdata_i;
                OFS_NOTIFY: begin
                    st_d.notify = 1'b1;
                    st_d.nidx   = bus_wdata_i;
                end
                default: ;
            endcase
        end
        if (bus_rd_i) begin
            unique case (bus_addr_i)
                OFS_MAXSZ:   st_d.rdata = sel_ok ? DW'(MAX_ENTRIES) : '0;
                OFS_QPFN:    st_d.rdata = pfn_sel;
                OFS_IRQSTAT: st_d.rdata = DW'(status);
                OFS_QBASE:   st_d.rdata = base_sel;
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pvq_queue_bank #(.NUM_Q(NUM_Q), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_size_i (wr_size),
        .wr_align_i(wr_align),
        .wr_pfn_i  (wr_pfn),
        .idx_i     (sel_idx),
        .wdata_i   (bus_wdata_i),
        .size_o    (q_size_o),
        .align_o   (q_align_o),
        .pfn_o     (q_pfn_o)
    );

    pvq_irq_status #(.ST_W(ST_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .ack_en_i  (ack_en),
        .ack_mask_i(bus_wdata_i[ST_W-1:0]),
        .status_o  (status),
        .irq_o     (irq_o)
    );

    assign bus_rdata_o   = st_q.rdata;
    assign notify_o      = st_q.notify;
    assign notify_qidx_o = st_q.nidx;
    assign page_size_o   = st_q.page;

    assign rd_wo = (bus_addr_i == OFS_QSEL)   || (bus_addr_i == OFS_QSIZE)  ||
                   (bus_addr_i == OFS_QALIGN) || (bus_addr_i == OFS_PGSIZE) ||
                   (bus_addr_i == OFS_NOTIFY) || (bus_addr_i == OFS_IRQACK);

    assert_wo_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && rd_wo) |=> (bus_rdata_o == '0));

    assert_oob_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && !sel_ok) |=> ($stable(q_pfn_o) && $stable(q_size_o) && $stable(q_align_o)));

    assert_oob_maxsz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == OFS_MAXSZ && !sel_ok) |=> (bus_rdata_o == '0));

    assert_notify_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == OFS_NOTIFY) |=> (notify_o && notify_qidx_o == $past(bus_wdata_i)));

    assert_notify_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && bus_addr_i == OFS_NOTIFY) |=> !notify_o);

endmodule

// File: tb/tb_pvq_mmio_regs.sv
module tb_pvq_mmio_regs;
    import pvq_pkg::*;

    localparam int NQ   = 4;
    localparam int MAXE = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr_i = '0;
    logic            bus_wr_i = 1'b0;
    logic [31:0]     bus_wdata_i = '0;
    logic            bus_rd_i = 1'b0;
    logic [31:0]     bus_rdata_o;
    logic            evt_used_i = 1'b0;
    logic            evt_cfg_i = 1'b0;
    logic            irq_o;
    logic            notify_o;
    logic [31:0]     notify_qidx_o;
    logic [31:0]     page_size_o;
    logic [NQ*32-1:0] q_size_o, q_align_o, q_pfn_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    pvq_mmio_regs #(.NUM_Q(NQ), .MAX_ENTRIES(MAXE)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rd_i(bus_rd_i), .bus_rdata_o(bus_rdata_o),
        .evt_used_i(evt_used_i), .evt_cfg_i(evt_cfg_i), .irq_o(irq_o),
        .notify_o(notify_o), .notify_qidx_o(notify_qidx_o),
        .page_size_o(page_size_o), .q_size_o(q_size_o),
        .q_align_o(q_align_o), .q_pfn_o(q_pfn_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    // monitor: pops the expected read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= bus_rd_i;

    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen) begin
                if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
                else chk(tag_q.pop_front(), bus_rdata_o, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd_i = 1'b1; bus_addr_i = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd_i = 1'b0;
    endtask

    task automatic pulse(input logic used, input logic cfg);
        @(negedge clk);
        evt_used_i = used; evt_cfg_i = cfg;
        @(negedge clk);
        evt_used_i = 1'b0; evt_cfg_i = 1'b0;
    endtask

    initial begin
        #1ms;
        if (!done) begin
            chk("watchdog expired", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 notify_o", {31'd0, notify_o}, 32'd0);
        chk("R1 page_size_o", page_size_o, 32'd0);
        chk("R1 q_pfn_o low", q_pfn_o[31:0], 32'd0);
        rd_expect(OFS_IRQSTAT, 32'd0, "R1 status");
        rd_expect(OFS_QPFN, 32'd0, "R3 pfn q0 at reset");
        rd_expect(OFS_MAXSZ, MAXE, "R4 maxsz q0");

        // program queues
        wr(OFS_PGSIZE, 32'd4096);
        for (int q = 0; q < NQ; q++) begin
            wr(OFS_QSEL, q);
            wr(OFS_QSIZE, 32'd16 * (q + 1));
            wr(OFS_QALIGN, 32'd64 << q);
            if (q < 3) wr(OFS_QPFN, 32'h100 + q);
        end
        chk("R12 page_size_o", page_size_o, 32'd4096);
        for (int q = 0; q < NQ; q++) begin
            chk("R12 q_size_o", q_size_o[q*32 +: 32], 32'd16 * (q + 1));
            chk("R12 q_align_o", q_align_o[q*32 +: 32], 32'd64 << q);
        end
        for (int q = 0; q < 3; q++) begin
            wr(OFS_QSEL, q);
            rd_expect(OFS_QPFN, 32'h100 + q, "R2 pfn readback");
            rd_expect(OFS_QBASE, (32'h100 + q) * 32'd4096, "R5 base");
        end
        wr(OFS_QSEL, 3);
        rd_expect(OFS_QPFN, 32'd0, "R3 unused queue pfn");
        rd_expect(OFS_MAXSZ, MAXE, "R4 maxsz q3");

        // out-of-range selection
        wr(OFS_QSEL, 5);
        rd_expect(OFS_MAXSZ, 32'd0, "R4 maxsz oob");
        wr(OFS_QPFN, 32'h55);
        wr(OFS_QSIZE, 32'h77);
        rd_expect(OFS_QPFN, 32'd0, "R4 pfn oob read");
        chk("R4 q1 pfn untouched", q_pfn_o[63:32], 32'h101);
        chk("R4 q3 pfn untouched", q_pfn_o[127:96], 32'd0);
        chk("R4 q1 size untouched", q_size_o[63:32], 32'd32);

        // page size rescale
        wr(OFS_QSEL, 1);
        wr(OFS_PGSIZE, 32'd8192);
        rd_expect(OFS_QBASE, 32'h101 * 32'd8192, "R5 base after rescale");

        // direction rules
        rd_expect(OFS_QSEL, 32'd0, "R10 read qsel");
        rd_expect(OFS_QSIZE, 32'd0, "R10 read qsize");
        rd_expect(OFS_QALIGN, 32'd0, "R10 read qalign");
        rd_expect(OFS_PGSIZE, 32'd0, "R10 read pgsize");
        rd_expect(OFS_NOTIFY, 32'd0, "R10 read notify");
        rd_expect(OFS_IRQACK, 32'd0, "R10 read irqack");
        wr(OFS_MAXSZ, 32'h1234);
        rd_expect(OFS_MAXSZ, MAXE, "R10 maxsz write ignored");
        wr(OFS_IRQSTAT, 32'h3);
        chk("R10 status write ignored irq", {31'd0, irq_o}, 32'd0);
        rd_expect(OFS_IRQSTAT, 32'd0, "R10 status write ignored");
        wr(8'h80, 32'hFFFF_FFFF);
        rd_expect(8'h80, 32'd0, "R10 unmapped read");
        rd_expect(OFS_QPFN, 32'h101, "R10 unmapped write ignored");

        // notify pulse
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = OFS_NOTIFY; bus_wdata_i = 32'd2;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_wdata_i = '0;
        chk("R11 notify high", {31'd0, notify_o}, 32'd1);
        chk("R11 notify index", notify_qidx_o, 32'd2);
        @(negedge clk);
        chk("R11 notify single cycle", {31'd0, notify_o}, 32'd0);

        // interrupt causes
        pulse(1'b1, 1'b0);
        chk("R6 irq after used event", {31'd0, irq_o}, 32'd1);
        rd_expect(OFS_IRQSTAT, 32'd1, "R8 used bit 0");
        pulse(1'b0, 1'b1);
        rd_expect(OFS_IRQSTAT, 32'd3, "R8 cfg bit 1");
        wr(OFS_IRQACK, 32'd0);
        rd_expect(OFS_IRQSTAT, 32'd3, "R7 zero mask keeps");
        wr(OFS_IRQACK, 32'd1);
        rd_expect(OFS_IRQSTAT, 32'd2, "R7 clear bit 0 only");
        chk("R6 irq still high", {31'd0, irq_o}, 32'd1);
        wr(OFS_IRQACK, 32'd2);
        chk("R6 irq low after clear", {31'd0, irq_o}, 32'd0);

        // set and acknowledge in one cycle
        @(negedge clk);
        evt_used_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = OFS_IRQACK; bus_wdata_i = 32'd1;
        @(negedge clk);
        evt_used_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = '0;
        chk("R9 set wins irq", {31'd0, irq_o}, 32'd1);
        rd_expect(OFS_IRQSTAT, 32'd1, "R9 set wins status");
        wr(OFS_IRQACK, 32'd3);
        chk("R7 final clear", {31'd0, irq_o}, 32'd0);

        repeat (3) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule